// File: doc/BRIEF.md
# Backlight PWM Generator

This block turns the pixel clock into a pulse-width modulated backlight drive. A programmable prescaler divides the clock by (N + 1), and every prescaled tick advances an 8-bit period counter. A full PWM period therefore spans 256 ticks. The output is high for the first D + 1 ticks of each period, where D is the 8-bit duty value.

Software programs the block through two registers. The frequency register holds the divisor N in bits [21:0] and a run enable in bit 22. The duty register holds D in bits [7:0]. The static parameter `ALT_MAP` picks one of two address layouts. To turn the backlight fully dark, software clears the enable bit. Lowering the duty value cannot do this, because D = 0 still gives one tick high.

A divisor or duty value written while the generator runs is held back until the current period ends. The output therefore never shows a truncated or stretched pulse.

Top module: `blpwm_top`

## Requirements
- R1: After reset, `pwmOut` is low and both registers read back as zero.
- R2: The frequency register reads back the divisor in bits [21:0] and the enable in bit 22, with bits [31:23] reading zero. The duty register reads back D in bits [7:0], with all higher bits reading zero.
- R3: With `ALT_MAP`=0, the frequency register is at 0x34 and the duty register at 0x38. With `ALT_MAP`=1, they are at 0x4C and 0x50. Writes to any other address change nothing, and reads of any other address return zero.
- R4: While enabled, the prescaler ticks once every N + 1 clocks, and one PWM period lasts 256 × (N + 1) clocks.
- R5: With duty value D, `pwmOut` is high for (D + 1) × (N + 1) clocks at the start of each period. With D = 255, it is high continuously.
- R6: Clearing the enable bit forces `pwmOut` low from the clock after the write and holds both counters at zero. Setting the bit again restarts a period from tick zero, with `pwmOut` high from the clock after the write.
- R7: A divisor or duty value written while running takes effect only at the start of the next PWM period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| pwmOut | output | 1 | Backlight PWM output |

## Verification
A wrong prescaler or period count shows up within a single period as a wrong high-time total over a window one or two periods long. A shadow value that is loaded too early shows up within the period in which a mid-period write lands: it changes the high count of that period. A counter that is not cleared on disable shows up on the next enable, because the first period's high time no longer starts at tick zero. That error appears inside the first 256 × (N + 1) clocks.

// File: rtl/blpwm_pkg.sv
package blpwm_pkg;
  localparam int unsigned PERIOD_W = 8;

  typedef struct packed {
    logic active;   // counters may run
    logic hold;     // force output low, counters cleared
  } pwmStrobes_t;
endpackage

// File: rtl/blpwm_regs.sv
module blpwm_regs
  import blpwm_pkg::*;
#(
  parameter bit          ALT_MAP = 1'b0,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 22,
  parameter int unsigned DUTY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [DIV_W-1:0]  divReg,
  output logic [DUTY_W-1:0] dutyReg,
  output logic              enBit,
  output logic              runQ,
  output pwmStrobes_t       strobes
);
  localparam int unsigned FREQ_OFS = ALT_MAP ? 32'h4C : 32'h34;
  localparam int unsigned DUTY_OFS = FREQ_OFS + 4;
  localparam logic [ADDR_W-1:0] FREQ_ADDR = FREQ_OFS[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] DUTY_ADDR = DUTY_OFS[ADDR_W-1:0];

  logic freqSel;
  logic dutySel;

  assign freqSel = (regAddr == FREQ_ADDR);
  assign dutySel = (regAddr == DUTY_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= '0;
      enBit   <= 1'b0;
      dutyReg <= '0;
      runQ    <= 1'b0;
    end else begin
      runQ <= enBit;
      if (regWrEn && freqSel) begin
        divReg <= regWrData[DIV_W-1:0];
        enBit  <= regWrData[DIV_W];
      end
      if (regWrEn && dutySel) begin
        dutyReg <= regWrData[DUTY_W-1:0];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (freqSel) begin
      regRdData[DIV_W:0] = {enBit, divReg};
    end else if (dutySel) begin
      regRdData[DUTY_W-1:0] = dutyReg;
    end
  end

  assign strobes.active = enBit && runQ;
  assign strobes.hold   = !enBit;
endmodule

// File: rtl/blpwm_core.sv
module blpwm_core
  import blpwm_pkg::*;
#(
  parameter int unsigned DIV_W  = 22,
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobes_t       strobes,
  input  logic [DIV_W-1:0]  divReg,
  input  logic [DUTY_W-1:0] dutyReg,
  output logic              pwmOut,
  output logic [DIV_W-1:0]  prescCnt,
  output logic [DUTY_W-1:0] periodCnt,
  output logic [DIV_W-1:0]  divAct,
  output logic [DUTY_W-1:0] dutyAct
);
  localparam logic [DUTY_W-1:0] PERIOD_LAST = '1;

  logic              tick;
  logic              loadShadow;
  logic [DIV_W-1:0]  prescN;
  logic [DUTY_W-1:0] periodN;
  logic [DIV_W-1:0]  divN;
  logic [DUTY_W-1:0] dutyN;
  logic              pwmN;

  assign tick       = (prescCnt == divAct);
  assign loadShadow = !strobes.active || (tick && periodCnt == PERIOD_LAST);

  always_comb begin
    if (!strobes.active) begin
      prescN  = '0;
      periodN = '0;
    end else begin
      prescN  = tick ? '0 : prescCnt + 1'b1;
      periodN = tick ? periodCnt + 1'b1 : periodCnt;
    end
    divN  = loadShadow ? divReg  : divAct;
    dutyN = loadShadow ? dutyReg : dutyAct;
    pwmN  = !strobes.hold && (periodN <= dutyN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt  <= '0;
      periodCnt <= '0;
      divAct    <= '0;
      dutyAct   <= '0;
      pwmOut    <= 1'b0;
    end else begin
      prescCnt  <= prescN;
      periodCnt <= periodN;
      divAct    <= divN;
      dutyAct   <= dutyN;
      pwmOut    <= pwmN;
    end
  end
endmodule

// File: rtl/blpwm_top.sv
module blpwm_top
  import blpwm_pkg::*;
#(
  parameter bit          ALT_MAP = 1'b0,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              pwmOut
);
  localparam int unsigned DUTY_W = PERIOD_W;

  pwmStrobes_t       strobes;
  logic [DIV_W-1:0]  divReg;
  logic [DUTY_W-1:0] dutyReg;
  logic              enBit;
  logic              runQ;
  logic [DIV_W-1:0]  prescCnt;
  logic [DUTY_W-1:0] periodCnt;
  logic [DIV_W-1:0]  divAct;
  logic [DUTY_W-1:0] dutyAct;

  blpwm_regs #(
    .ALT_MAP(ALT_MAP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DIV_W(DIV_W), .DUTY_W(DUTY_W)
  ) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .divReg(divReg),
    .dutyReg(dutyReg), .enBit(enBit), .runQ(runQ), .strobes(strobes)
  );

  blpwm_core #(.DIV_W(DIV_W), .DUTY_W(DUTY_W)) core_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .divReg(divReg),
    .dutyReg(dutyReg), .pwmOut(pwmOut), .prescCnt(prescCnt),
    .periodCnt(periodCnt), .divAct(divAct), .dutyAct(dutyAct)
  );
endmodule

// File: rtl/blpwm_chk.sv
module blpwm_chk #(
  parameter int unsigned DIV_W  = 22,
  parameter int unsigned DUTY_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwmOut,
  input logic              enBit,
  input logic              runQ,
  input logic [DIV_W-1:0]  prescCnt,
  input logic [DUTY_W-1:0] periodCnt,
  input logic [DIV_W-1:0]  divAct,
  input logic [DUTY_W-1:0] dutyAct
);
  localparam logic [DUTY_W-1:0] LAST = '1;

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !pwmOut); // R6
  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (prescCnt == '0 && periodCnt == '0)); // R6
  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= divAct); // R4
  AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (prescCnt != divAct) |=> ($stable(periodCnt) || periodCnt == '0)); // R4
  AST_DUTY_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && runQ) |-> (pwmOut == (periodCnt <= dutyAct))); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && runQ && !(prescCnt == divAct && periodCnt == LAST))
      |=> ($stable(divAct) && $stable(dutyAct))); // R7
endmodule

bind blpwm_top blpwm_chk #(.DIV_W(DIV_W), .DUTY_W(DUTY_W)) chk_i (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut), .enBit(enBit), .runQ(runQ),
  .prescCnt(prescCnt), .periodCnt(periodCnt), .divAct(divAct),
  .dutyAct(dutyAct)
);

// File: tb/blpwm_top_tb_top.sv
`timescale 1ns/1ps
module blpwm_top_tb_top;
  localparam logic [31:0] EN = 32'h0040_0000;

  typedef struct {
    int    win;
    int    exp;
    string tag;
  } sbItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdData;
  logic [31:0] rdDataAlt;
  logic        pwmOut;
  logic        pwmAlt;

  int checks = 0;
  int fails  = 0;
  sbItem_t sbQ[$];
  event startEv;
  event doneEv;

  always #10 clk = ~clk;

  blpwm_top #(.ALT_MAP(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdData), .pwmOut(pwmOut)
  );

  blpwm_top #(.ALT_MAP(1'b1)) dutAlt_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdDataAlt), .pwmOut(pwmAlt)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
  endtask

  task automatic readBoth(input logic [11:0] a, output logic [31:0] v, output logic [31:0] vAlt);
    @(negedge clk);
    regAddr = a;
    #1;
    v = rdData;
    vAlt = rdDataAlt;
  endtask

  // Driver side: queue the expected high count, then start the window on the next edge.
  task automatic startWindow(input int win, input int exp, input string tag);
    sbItem_t it;
    it.win = win; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk);
    ->startEv;
  endtask

  // Monitor: counts high cycles of pwmOut over the queued window.
  initial begin
    forever begin
      sbItem_t it;
      int cnt;
      @(startEv);
      it = sbQ.pop_front();
      cnt = 0;
      for (int i = 0; i < it.win; i++) begin
        @(negedge clk);
        if (pwmOut) cnt++;
      end
      check(cnt == it.exp, it.tag, cnt, it.exp);
      ->doneEv;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, vA;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(pwmOut == 1'b0, "R1 pwmOut after reset", pwmOut, 0);
    readBoth(12'h034, v, vA);
    check(v == 0, "R1 freq reg reset", v, 0);
    readBoth(12'h038, v, vA);
    check(v == 0, "R1 duty reg reset", v, 0);

    // R2 field layout
    regWrite(12'h034, 32'hFFC0_0005);
    readBoth(12'h034, v, vA);
    check(v == 32'h0040_0005, "R2 freq readback", v, 32'h0040_0005);
    regWrite(12'h034, 32'h0);
    regWrite(12'h038, 32'h0000_1234);
    readBoth(12'h038, v, vA);
    check(v == 32'h34, "R2 duty readback", v, 32'h34);

    // R3 address maps
    readBoth(12'h04C, v, vA);
    check(vA == 0, "R3 alt map ignored 0x34 write", vA, 0);
    check(v == 0, "R3 default map reads 0x4C as zero", v, 0);
    regWrite(12'h050, 32'h77);
    readBoth(12'h050, v, vA);
    check(vA == 32'h77, "R3 alt duty at 0x50", vA, 32'h77);
    readBoth(12'h038, v, vA);
    check(v == 32'h34, "R3 default duty unchanged by 0x50 write", v, 32'h34);
    regWrite(12'h040, 32'hFFFF_FFFF);
    readBoth(12'h040, v, vA);
    check(v == 0, "R3 unmapped read zero", v, 0);
    readBoth(12'h034, v, vA);
    check(v == 0, "R3 unmapped write ignored", v, 0);

    // R4 period length: D=0, N=2, two periods
    regWrite(12'h038, 32'h0);
    regWrite(12'h034, EN | 32'd2);
    startWindow(2 * 256 * 3, 2 * 3, "R4 period 256*(N+1), N=2");
    @(doneEv);
    regWrite(12'h034, 32'h0);

    // R5 duty D=100, N=1
    regWrite(12'h038, 32'd100);
    regWrite(12'h034, EN | 32'd1);
    startWindow(2 * 512, 2 * 101 * 2, "R5 duty D=100 N=1");
    @(doneEv);
    regWrite(12'h034, 32'h0);

    // R5 duty D=255 always high
    regWrite(12'h038, 32'd255);
    regWrite(12'h034, EN);
    startWindow(256, 256, "R5 duty D=255 full");
    @(doneEv);
    regWrite(12'h034, 32'h0);
    @(negedge clk);
    check(pwmAlt == 1'b0, "R3 alt instance never enabled", pwmAlt, 0);

    // R6 disable mid-period then restart
    regWrite(12'h038, 32'd50);
    regWrite(12'h034, EN);
    repeat (20) @(posedge clk);
    regWrite(12'h034, 32'h0);
    startWindow(300, 0, "R6 low while disabled");
    @(doneEv);
    regWrite(12'h034, EN);
    startWindow(256, 51, "R6 restart from tick zero");
    @(doneEv);
    regWrite(12'h034, 32'h0);

    // R7 duty change deferred to next period
    regWrite(12'h038, 32'd0);
    regWrite(12'h034, EN);
    startWindow(512, 1 + 101, "R7 duty update at period start");
    repeat (50) @(posedge clk);
    regWrite(12'h038, 32'd100);
    @(doneEv);
    regWrite(12'h034, 32'h0);

    // R7 divisor change deferred to next period
    regWrite(12'h038, 32'd0);
    regWrite(12'h034, EN);
    startWindow(256 + 512, 1 + 2, "R7 divisor update at period start");
    repeat (50) @(posedge clk);
    regWrite(12'h034, EN | 32'd1);
    @(doneEv);
    regWrite(12'h034, 32'h0);

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule